// File: doc/BRIEF.md
# Table-Lookup Cipher Round Engine

This block computes a single round of an AES-style cipher on a 128-bit state split into four 32-bit words. Its substitution tables are not stored inside it. It reads them from an external word memory through a pipelined read port, using table base addresses that the host supplies at runtime. Before each round the host loads the parameter window: eight table bases, one final-round base, four state words and four round-key words. It then pulses `start`. The host keeps the round loop and the key schedule.

A sequencer issues sixteen table reads, one per cycle, through a short address pipeline. Each table address is built in three registered steps: select and shift the word, mask and scale the byte, then add the base. Read data return in request order after a fixed latency, with no back-pressure. Each returned word is folded by XOR into one of four accumulators that start out holding the round key. When the sixteenth response has been absorbed, `done` pulses and `out_state` carries the new state. Encryption and decryption share this datapath. A mode bit chooses one of two sets of table bases, and a final-round flag sends all lookups to one separate table.

Top module: `ttr_round_engine`

## Requirements
- R1: After reset, `done` and `rd_en` are low and `out_state` is zero.
- R2: A parameter write at address PARAM_BASE+n (default PARAM_BASE is 0x20) stores `pw_data` as follows. n=0..3 are the encrypt bases E0..E3, n=4..7 the decrypt bases D0..D3, n=8 the final-round base F, n=9..12 the state words s0..s3, and n=13..16 the key words k0..k3. Writes to any other address change nothing.
- R3: Output word i equals k_i XOR T0[byte3(s_i)] XOR T1[byte2(s_(i-1))] XOR T2[byte1(s_(i-2))] XOR T3[byte0(s_(i-3))]. Word indices are taken mod 4, byte3 is bits 31:24 and byte0 is bits 7:0, and word 0 sits in `out_state[127:96]`.
- R4: The read address for lookup k equals the base of table k plus 4 times the selected byte.
- R5: If `mode_dec` is 0 when `start` is accepted, the tables use bases E0..E3. If it is 1, they use D0..D3.
- R6: If `last_round` is 1 when `start` is accepted, all four lookups use base F, whatever the mode.
- R7: Each round issues exactly 16 reads on 16 consecutive cycles, ordered by output word and then by lookup.
- R8: With read latency N, `done` is high only in the cycle that begins 19+N clock edges after the edge that accepts `start`, and it is high for one cycle only.
- R9: `start`, `mode_dec` and `last_round` have no effect while a round is in progress.
- R10: Parameter writes made while a round is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pw_en | input | 1 | Parameter write strobe |
| pw_addr | input | PARAM_AW | Parameter write address |
| pw_data | input | DATA_W | Parameter write data |
| start | input | 1 | Begin a round (single-cycle pulse) |
| mode_dec | input | 1 | Selects the decrypt table bases |
| last_round | input | 1 | Selects the final-round table for all lookups |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Byte address of the requested table word |
| rsp_valid | input | 1 | Read data valid, in request order |
| rsp_data | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |
| out_state | output | 4*DATA_W | Result words, word 0 in the top bits |

## Verification
Four stimulus vectors cover the main function. An all-zero state makes every lookup hit entry 0, so only the bases and the key separate the results. An all-ones state does the same at entry 255. Two mixed states have a distinct byte in every position, which exposes wrong word rotation or a wrong byte shift. The vectors cover encrypt, decrypt and final-round selection, so a swapped base set or a mode flag that is not applied produces a different result. Directed runs then toggle `start`, the mode and the parameters in the middle of a round, and check that the round returns its original result.

// File: rtl/ttr_pkg.sv
package ttr_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} eng_state_e;
  localparam int NWORDS    = 4;
  localparam int NLOOK     = NWORDS * 4;
  localparam int OFS_ENC   = 0;
  localparam int OFS_DEC   = 4;
  localparam int OFS_LAST  = 8;
  localparam int OFS_STATE = 9;
  localparam int OFS_KEY   = 13;
  localparam int NREGS     = 17;
endpackage

// File: rtl/ttr_param_regs.sv
module ttr_param_regs import ttr_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int PARAM_AW   = 8,
  parameter int PARAM_BASE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PARAM_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                lock,
  output logic [ADDR_W-1:0]   enc_base [NWORDS],
  output logic [ADDR_W-1:0]   dec_base [NWORDS],
  output logic [ADDR_W-1:0]   last_base,
  output logic [DATA_W-1:0]   state_w  [NWORDS],
  output logic [DATA_W-1:0]   key_w    [NWORDS]
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [PARAM_AW-1:0] MY_ADDR = PARAM_AW'(PARAM_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && !lock && wr_addr == MY_ADDR)
        regs[g] <= wr_data;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_out
    assign enc_base[w] = ADDR_W'(regs[OFS_ENC + w]);
    assign dec_base[w] = ADDR_W'(regs[OFS_DEC + w]);
    assign state_w[w]  = regs[OFS_STATE + w];
    assign key_w[w]    = regs[OFS_KEY + w];
  end
  assign last_base = ADDR_W'(regs[OFS_LAST]);
endmodule

// File: rtl/ttr_addr_pipe.sv
module ttr_addr_pipe import ttr_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_idx,
  input  logic [DATA_W-1:0] state_w  [NWORDS],
  input  logic [ADDR_W-1:0] base_sel [NWORDS],
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [1:0] wsel, lk;
  logic [4:0] shamt;
  assign wsel = in_idx[3:2] - in_idx[1:0];
  assign lk   = in_idx[1:0];

  // Byte order variant: lookup 0 takes the top byte, or the bottom byte.
  if (MSB_FIRST) begin : g_msb
    assign shamt = {~lk, 3'b000};
  end else begin : g_lsb
    assign shamt = {lk, 3'b000};
  end

  // Stage A: shifted byte; stage B: scaled index; stage C: base added.
  logic             va, vb;
  logic [1:0]       ka, kb;
  logic [7:0]       sh_q;
  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va <= 1'b0; vb <= 1'b0; rd_en <= 1'b0;
      ka <= '0; kb <= '0; sh_q <= '0; idx_q <= '0; rd_addr <= '0;
    end else begin
      va      <= in_valid;
      ka      <= lk;
      sh_q    <= 8'(state_w[wsel] >> shamt);
      vb      <= va;
      kb      <= ka;
      idx_q   <= ADDR_W'({sh_q, 2'b00});
      rd_en   <= vb;
      rd_addr <= base_sel[kb] + idx_q;
    end
  end
endmodule

// File: rtl/ttr_xor_accum.sv
module ttr_xor_accum import ttr_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              armed,
  input  logic [DATA_W-1:0] key_w [NWORDS],
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] acc   [NWORDS],
  output logic              last_hit
);
  logic [4:0] cnt;
  logic       take;
  assign take     = armed && rsp_valid && !cnt[4];
  assign last_hit = take && cnt == 5'(NLOOK - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int w = 0; w < NWORDS; w++) acc[w] <= '0;
    end else if (init) begin
      cnt <= '0;
      for (int w = 0; w < NWORDS; w++) acc[w] <= key_w[w];
    end else if (take) begin
      cnt <= cnt + 5'd1;
      acc[cnt[3:2]] <= acc[cnt[3:2]] ^ rsp_data;
    end
  end
endmodule

// File: rtl/ttr_round_engine.sv
module ttr_round_engine import ttr_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int PARAM_AW   = 8,
  parameter int PARAM_BASE = 32,
  parameter bit MSB_FIRST  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pw_en,
  input  logic [PARAM_AW-1:0]   pw_addr,
  input  logic [DATA_W-1:0]     pw_data,
  input  logic                  start,
  input  logic                  mode_dec,
  input  logic                  last_round,
  output logic                  rd_en,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rsp_valid,
  input  logic [DATA_W-1:0]     rsp_data,
  output logic                  done,
  output logic [4*DATA_W-1:0]   out_state
);
  eng_state_e       state_q;
  logic [4:0]       iss_q;
  logic             mode_q, last_q, last_hit, issue_v, init;
  logic [ADDR_W-1:0] enc_base [NWORDS];
  logic [ADDR_W-1:0] dec_base [NWORDS];
  logic [ADDR_W-1:0] base_sel [NWORDS];
  logic [ADDR_W-1:0] last_base;
  logic [DATA_W-1:0] state_w  [NWORDS];
  logic [DATA_W-1:0] key_w    [NWORDS];
  logic [DATA_W-1:0] acc      [NWORDS];

  assign init    = state_q == ST_IDLE && start;
  assign issue_v = state_q == ST_RUN && !iss_q[4];

  ttr_param_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PARAM_AW(PARAM_AW),
                   .PARAM_BASE(PARAM_BASE)) u_regs (
    .clk, .rst_n, .wr_en(pw_en), .wr_addr(pw_addr), .wr_data(pw_data),
    .lock(state_q != ST_IDLE), .enc_base, .dec_base, .last_base, .state_w, .key_w);

  for (genvar k = 0; k < NWORDS; k++) begin : g_base
    assign base_sel[k] = last_q ? last_base : (mode_q ? dec_base[k] : enc_base[k]);
  end

  ttr_addr_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSB_FIRST(MSB_FIRST)) u_pipe (
    .clk, .rst_n, .in_valid(issue_v), .in_idx(iss_q[3:0]), .state_w, .base_sel,
    .rd_en, .rd_addr);

  ttr_xor_accum #(.DATA_W(DATA_W)) u_acc (
    .clk, .rst_n, .init, .armed(state_q == ST_RUN), .key_w, .rsp_valid, .rsp_data,
    .acc, .last_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; iss_q <= '0; mode_q <= 1'b0; last_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN; iss_q <= '0;
          mode_q  <= mode_dec; last_q <= last_round;
        end
        ST_RUN: begin
          if (issue_v) iss_q <= iss_q + 5'd1;
          if (last_hit) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = state_q == ST_DONE;
  assign out_state = {acc[0], acc[1], acc[2], acc[3]};
endmodule

// File: rtl/ttr_round_engine_chk.sv
module ttr_round_engine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        st,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_valid,
  input logic              done,
  input logic [DATA_W-1:0] key0
);
  logic [4:0] n_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_rd <= '0;
    else if (st == 2'd0 && start) n_rd <= '0;
    else if (rd_en) n_rd <= n_rd + 5'd1;
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> n_rd < 5'd16);
  a_r7_all_reads_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> n_rd == 5'd16);
  a_r9_reads_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> st == 2'd1);
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[1:0] == 2'b00);
  a_r10_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |=> $stable(key0));
  a_r8_done_after_response: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_valid));
endmodule

bind ttr_round_engine ttr_round_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .start, .st(state_q), .rd_en, .rd_addr, .rsp_valid, .done,
  .key0(key_w[0]));

// File: tb/ttr_round_engine_test.sv
module ttr_round_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int PBASE      = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pw_en = 1'b0, start = 1'b0, mode_dec = 1'b0, last_round = 1'b0;
  logic [7:0]   pw_addr = '0;
  logic [31:0]  pw_data = '0, rsp_data, rd_addr;
  logic         rd_en, rsp_valid, done;
  logic [127:0] out_state;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, rd_cnt = 0, last_rd = 0, gap_cnt = 0;
  logic [31:0] first_addr;
  logic [31:0] m_enc [4], m_dec [4], m_st [4], m_key [4];
  logic [31:0] m_last;

  ttr_round_engine uut (.clk, .rst_n, .pw_en, .pw_addr, .pw_data, .start, .mode_dec,
    .last_round, .rd_en, .rd_addr, .rsp_valid, .rsp_data, .done, .out_state);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] tmem(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
  endfunction

  // Fixed-latency in-order memory model.
  logic [LAT-1:0] pv;
  logic [31:0]    pd [LAT];
  always @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else begin
      pv[0] <= rd_en; pd[0] <= tmem(rd_addr);
      for (int s = 1; s < LAT; s++) begin pv[s] <= pv[s-1]; pd[s] <= pd[s-1]; end
    end
  end
  assign rsp_valid = pv[LAT-1];
  assign rsp_data  = pd[LAT-1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      if (rd_cnt == 0) first_addr <= rd_addr;
      else if (cyc != last_rd + 1) gap_cnt <= gap_cnt + 1;
      rd_cnt  <= rd_cnt + 1;
      last_rd <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk); pw_en = 1'b1; pw_addr = 8'(PBASE + ofs); pw_data = d;
    @(negedge clk); pw_en = 1'b0;
  endtask

  function automatic logic [127:0] model(input bit md, input bit lr);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = m_key[i];
      for (int k = 0; k < 4; k++) begin
        logic [31:0] w, b, base;
        w    = m_st[(i - k + 4) % 4];
        b    = (w >> (24 - 8*k)) & 32'hFF;
        base = lr ? m_last : (md ? m_dec[k] : m_enc[k]);
        a    = a ^ tmem(base + b * 4);
      end
      r[127 - 32*i -: 32] = a;
    end
    return r;
  endfunction

  // Runs one round; optionally disturbs inputs mid-run.
  task automatic run(input bit md, input bit lr, input bit disturb, output int lat,
                     output logic [127:0] res);
    int k;
    @(negedge clk); rd_cnt = 0; gap_cnt = 0;
    start = 1'b1; mode_dec = md; last_round = lr;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    k = 0;
    do begin
      if (disturb && k == 5) begin
        start = 1'b1; mode_dec = ~md; last_round = ~lr;
        pw_en = 1'b1; pw_addr = 8'(PBASE + 13); pw_data = 32'hDEADBEEF;
      end else begin
        start = 1'b0; pw_en = 1'b0;
      end
      @(posedge clk); k++;
      @(negedge clk);
    end while (!done && k < 300);
    start = 1'b0; pw_en = 1'b0; mode_dec = md; last_round = lr;
    lat = k; res = out_state;
    chk(k < 300, "R8 watchdog", 128'(k), 128'(19 + LAT));
    @(negedge clk);
    chk(!done, "R8 done one cycle", 128'(done), 128'(0));
  endtask

  typedef struct packed {
    logic [31:0] s0, s1, s2, s3, k0, k1, k2, k3;
    logic md, lr;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444, 1'b0, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0},
    '{32'h00112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFF, 32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0, 1'b0, 1'b0},
    '{32'h3A7C19E2, 32'hB40D6F85, 32'h2C91D7A0, 32'h5EF3184B, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h01234567, 32'h89ABCDEF, 1'b1, 1'b1}
  };

  task automatic load_vec(input vec_t v);
    m_st  = '{v.s0, v.s1, v.s2, v.s3};
    m_key = '{v.k0, v.k1, v.k2, v.k3};
    for (int i = 0; i < 4; i++) begin wr(9 + i, m_st[i]); wr(13 + i, m_key[i]); end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] res, exp;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(!done && !rd_en && out_state == '0, "R1 reset state", out_state, 128'(0));
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      m_enc[i] = 32'h1000 * (i + 1);
      m_dec[i] = 32'h5000 + 32'h1000 * i;
      wr(i, m_enc[i]); wr(4 + i, m_dec[i]);
    end
    m_last = 32'h9000; wr(8, m_last);

    for (int v = 0; v < 4; v++) begin
      load_vec(VECS[v]);
      run(VECS[v].md, VECS[v].lr, 1'b0, lat, res);
      exp = model(VECS[v].md, VECS[v].lr);
      chk(res == exp, "R3/R5/R6 result", res, exp);
      chk(lat == 19 + LAT, "R8 latency", 128'(lat), 128'(19 + LAT));
      chk(rd_cnt == 16 && gap_cnt == 0, "R7 read count and spacing", 128'(rd_cnt), 128'(16));
    end

    // R4 first address: table 0 of the selected set, byte3 of s0, times 4.
    load_vec(VECS[2]);
    run(1'b0, 1'b0, 1'b0, lat, res);
    chk(first_addr == m_enc[0] + 32'h00 * 4, "R4 first address", 128'(first_addr), 128'(m_enc[0]));
    load_vec(VECS[3]);
    run(1'b0, 1'b0, 1'b0, lat, res);
    chk(first_addr == m_enc[0] + 32'h3A * 4, "R4 scaled index", 128'(first_addr), 128'(m_enc[0] + 32'hE8));
    // R5 decrypt set with mixed data, R6 final-round overrides mode 0.
    run(1'b1, 1'b0, 1'b0, lat, res);
    chk(res == model(1'b1, 1'b0), "R5 decrypt bases", res, model(1'b1, 1'b0));
    run(1'b0, 1'b1, 1'b0, lat, res);
    chk(res == model(1'b0, 1'b1), "R6 final-round base", res, model(1'b0, 1'b1));

    // R2: writes just outside the window must change nothing.
    @(negedge clk); pw_en = 1'b1; pw_addr = 8'(PBASE - 1); pw_data = 32'h0BAD0BAD;
    @(negedge clk); pw_addr = 8'(PBASE + 17);
    @(negedge clk); pw_en = 1'b0;
    run(1'b1, 1'b0, 1'b0, lat, res);
    chk(res == model(1'b1, 1'b0), "R2 out-of-window write ignored", res, model(1'b1, 1'b0));

    // R9/R10: start, mode, final flag and a key write toggled mid-round.
    run(1'b0, 1'b0, 1'b1, lat, res);
    chk(res == model(1'b0, 1'b0), "R9 mid-round inputs ignored", res, model(1'b0, 1'b0));
    chk(lat == 19 + LAT, "R9 latency unchanged", 128'(lat), 128'(19 + LAT));
    rd_cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (done) chk(1'b0, "R9 no second round", 128'(1), 128'(0));
    end
    chk(rd_cnt == 0, "R9 no reads after round", 128'(rd_cnt), 128'(0));
    run(1'b0, 1'b0, 1'b0, lat, res);
    chk(res == model(1'b0, 1'b0), "R10 busy key write dropped", res, model(1'b0, 1'b0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule